// File: doc/BRIEF.md
# Arbiter Event Statistics Gatherer

This block watches the grant stream that a memory arbiter produces and counts selected events over a measured window. Two gatherers run side by side. Each has its own control word that picks an event type, an optional client to match, one arbitration flag (high-priority, timeout or bandwidth) and a filter mode on that flag. Both share a clock counter that measures the length of the window, so software can turn the two counts into utilisation figures after collection stops.

Software writes the two control words and the clock limit, then issues start and stop commands through a small word-addressed register port. Control words and the limit are held in staging registers and copied into the working set only when a start command lands. Stop freezes all three counters so they can be read at leisure. Some events depend on history: a read/write turnaround compares the grant with the previous grant's direction, and a successive win compares the granted client with the previous winner.

Top module: `arb_evstat`

## Requirements
- R1: After reset, collection is off, both counters and the clock count read 0, both control words read 0 and the limit reads all ones. Word addresses: 0 command, 1 clock limit, 2 control of gatherer 0, 3 control of gatherer 1, 4 clock count, 5 count of gatherer 0, 6 count of gatherer 1.
- R2: A write to word 0 carries a command in bits 9:8: 3 starts collection, 2 stops it, 1 zeroes the clock count and both event counts and forgets grant history without changing whether collection runs, 0 does the same zeroing and also stops (see R12).
- R3: While collecting, the clock count rises by one per cycle until it equals the working limit and then holds.
- R4: Event counts rise by one per counted grant, never decrease except through a zeroing command, and hold at all ones instead of wrapping.
- R5: Control word fields: client ID in bits 13:8, event select in 23:16, flag select in 25:24, client match enable in bit 26, flag filter mode in 29:28. With bit 26 clear the client ID field is ignored and grants from every client count.
- R6: Flag select 0 picks high-priority, 1 timeout, 2 bandwidth. Filter mode 0 counts regardless of the flag, 1 counts only grants with the flag low, 2 only grants with the flag high.
- R7: Event select 0 counts every qualifying grant, 1 reads only, 2 writes only, 5 grants flagged bank AA arbitration, 6 bank BB arbitration, 7 page miss, 8 auto-precharge.
- R8: Event select 3 counts a grant whose direction differs from the previous grant's direction; the first grant after reset or a zeroing command has no predecessor.
- R9: Event select 4 counts a grant whose client equals the previous grant's client, so N back-to-back grants to one client give N-1 events.
- R10: While collection is stopped, grants and cycles leave all three counters unchanged.
- R11: Writes to the control words and the limit only reach the staging copy; the working copy changes at the next start command, even when written during collection.
- R12: The reset command (0) also returns both staged control words to 0 and the staged limit to all ones.
- R13: Event select values above 8 never count, flag select 3 acts as a flag that is always low, and filter mode 3 acts as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| gnt_valid | input | 1 | A grant is issued this cycle |
| gnt_client | input | 6 | Client ID of the granted request |
| gnt_write | input | 1 | Granted request is a write (0 read) |
| gnt_hp | input | 1 | High-priority flag of the grant |
| gnt_tm | input | 1 | Timeout flag of the grant |
| gnt_bw | input | 1 | Bandwidth flag of the grant |
| gnt_page_miss | input | 1 | Grant causes a page miss |
| gnt_bank_aa | input | 1 | Bank AA arbitration event |
| gnt_bank_bb | input | 1 | Bank BB arbitration event |
| gnt_auto_pre | input | 1 | Grant carries auto-precharge |

## Verification
The assertions take for granted that the clock limit only changes at a start command and that a zeroing command is the only path by which a count may fall, so a frozen or growing counter is a property of the ports alone. They also rely on register writes and grants never sharing a cycle in a way that matters for history; the stimulus keeps every register write in an idle grant cycle. Random grants draw clients from a narrow range so that successive wins and direction changes happen often, and directed runs cover limit saturation, deferred control updates and the history reset.

// File: rtl/arb_evstat_pkg.sv
package arb_evstat_pkg;

  localparam int CLIENT_W = 6;
  localparam int NGATH    = 2;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTL0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLOCKS = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd5;

  typedef enum logic [1:0] {
    CMD_RESET = 2'd0,
    CMD_CLEAR = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_START = 2'd3
  } cmd_e;

  localparam logic [7:0] EV_QUAL  = 8'd0;
  localparam logic [7:0] EV_RD    = 8'd1;
  localparam logic [7:0] EV_WR    = 8'd2;
  localparam logic [7:0] EV_TURN  = 8'd3;
  localparam logic [7:0] EV_AGAIN = 8'd4;
  localparam logic [7:0] EV_BAA   = 8'd5;
  localparam logic [7:0] EV_BBB   = 8'd6;
  localparam logic [7:0] EV_PMISS = 8'd7;
  localparam logic [7:0] EV_APRE  = 8'd8;

  typedef struct packed {
    logic [1:0]          pmode;
    logic                cfen;
    logic [1:0]          psel;
    logic [7:0]          evsel;
    logic [CLIENT_W-1:0] client;
  } ctl_t;

  typedef struct packed {
    logic                valid;
    logic [CLIENT_W-1:0] client;
    logic                write;
    logic                hp;
    logic                tm;
    logic                bw;
    logic                pmiss;
    logic                bank_aa;
    logic                bank_bb;
    logic                apre;
  } grant_t;

  function automatic ctl_t ctl_decode(input logic [WORD_W-1:0] w);
    ctl_t c;
    c.client = w[13:8];
    c.evsel  = w[23:16];
    c.psel   = w[25:24];
    c.cfen   = w[26];
    c.pmode  = w[29:28];
    return c;
  endfunction

  function automatic logic prio_pass(input ctl_t c, input grant_t g);
    logic flag;
    logic pass;
    case (c.psel)
      2'd0:    flag = g.hp;
      2'd1:    flag = g.tm;
      2'd2:    flag = g.bw;
      default: flag = 1'b0;
    endcase
    case (c.pmode)
      2'd1:    pass = !flag;
      2'd2:    pass = flag;
      default: pass = 1'b1;
    endcase
    return pass;
  endfunction

  function automatic logic event_hit(input ctl_t c, input grant_t g,
                                     input logic turn, input logic again);
    logic sel;
    logic who;
    case (c.evsel)
      EV_QUAL:  sel = 1'b1;
      EV_RD:    sel = !g.write;
      EV_WR:    sel = g.write;
      EV_TURN:  sel = turn;
      EV_AGAIN: sel = again;
      EV_BAA:   sel = g.bank_aa;
      EV_BBB:   sel = g.bank_bb;
      EV_PMISS: sel = g.pmiss;
      EV_APRE:  sel = g.apre;
      default:  sel = 1'b0;
    endcase
    who = !c.cfen || (c.client == g.client);
    return g.valid && who && prio_pass(c, g) && sel;
  endfunction

endpackage

// File: rtl/arb_evstat_regs.sv
module arb_evstat_regs
  import arb_evstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic                en,
  output logic                zero,
  output ctl_t                ctl_act [NGATH],
  output logic [CNT_W-1:0]    lim_act,
  output logic [WORD_W-1:0]   ctl_stg [NGATH],
  output logic [CNT_W-1:0]    lim_stg,
  output logic [1:0]          cmd_last
);

  logic cmd_wr;
  cmd_e cmd;

  assign cmd_wr = we && (addr == A_CMD);
  assign cmd    = cmd_e'(wdata[9:8]);
  assign zero   = cmd_wr && ((cmd == CMD_RESET) || (cmd == CMD_CLEAR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      lim_act  <= '1;
      lim_stg  <= '1;
      cmd_last <= 2'd0;
      for (int i = 0; i < NGATH; i++) begin
        ctl_stg[i] <= '0;
        ctl_act[i] <= '0;
      end
    end else if (cmd_wr) begin
      cmd_last <= wdata[9:8];
      case (cmd)
        CMD_RESET: begin
          en      <= 1'b0;
          lim_stg <= '1;
          for (int i = 0; i < NGATH; i++) ctl_stg[i] <= '0;
        end
        CMD_STOP:  en <= 1'b0;
        CMD_START: begin
          en      <= 1'b1;
          lim_act <= lim_stg;
          for (int i = 0; i < NGATH; i++) ctl_act[i] <= ctl_decode(ctl_stg[i]);
        end
        default: ;
      endcase
    end else if (we) begin
      if (addr == A_LIMIT) lim_stg <= wdata[CNT_W-1:0];
      for (int i = 0; i < NGATH; i++) begin
        if (addr == A_CTL0 + ADDR_W'(i)) ctl_stg[i] <= wdata;
      end
    end
  end

endmodule

// File: rtl/arb_evstat_hist.sv
module arb_evstat_hist
  import arb_evstat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  grant_t g,
  output logic   turn,
  output logic   again
);

  logic                prev_v;
  logic                prev_w;
  logic [CLIENT_W-1:0] prev_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v <= 1'b0;
      prev_w <= 1'b0;
      prev_c <= '0;
    end else if (clr) begin
      prev_v <= 1'b0;
    end else if (g.valid) begin
      prev_v <= 1'b1;
      prev_w <= g.write;
      prev_c <= g.client;
    end
  end

  assign turn  = g.valid && prev_v && (prev_w != g.write);
  assign again = g.valid && prev_v && (prev_c == g.client);

endmodule

// File: rtl/arb_evstat_gather.sv
module arb_evstat_gather
  import arb_evstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             zero,
  input  ctl_t             ctl,
  input  grant_t           g,
  input  logic             turn,
  input  logic             again,
  output logic             inc,
  output logic [CNT_W-1:0] cnt
);

  function automatic logic [CNT_W-1:0] sat_next(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic hit;

  assign hit = event_hit(ctl, g, turn, again);
  assign inc = en && hit && !zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (zero) cnt <= '0;
    else if (inc)  cnt <= sat_next(cnt);
  end

endmodule

// File: rtl/arb_evstat.sv
module arb_evstat
  import arb_evstat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                gnt_valid,
  input  logic [5:0]          gnt_client,
  input  logic                gnt_write,
  input  logic                gnt_hp,
  input  logic                gnt_tm,
  input  logic                gnt_bw,
  input  logic                gnt_page_miss,
  input  logic                gnt_bank_aa,
  input  logic                gnt_bank_bb,
  input  logic                gnt_auto_pre
);

  grant_t            g;
  logic              en_q;
  logic              zero_fire;
  ctl_t              ctl_act [NGATH];
  logic [WORD_W-1:0] ctl_stg [NGATH];
  logic [CNT_W-1:0]  lim_act;
  logic [CNT_W-1:0]  lim_stg;
  logic [1:0]        cmd_last;
  logic              turn_ev;
  logic              again_ev;
  logic [CNT_W-1:0]  clk_cnt;
  logic [CNT_W-1:0]  cnt_q [NGATH];
  logic [NGATH-1:0]  inc;

  assign g.valid   = gnt_valid;
  assign g.client  = gnt_client;
  assign g.write   = gnt_write;
  assign g.hp      = gnt_hp;
  assign g.tm      = gnt_tm;
  assign g.bw      = gnt_bw;
  assign g.pmiss   = gnt_page_miss;
  assign g.bank_aa = gnt_bank_aa;
  assign g.bank_bb = gnt_bank_bb;
  assign g.apre    = gnt_auto_pre;

  arb_evstat_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .en       (en_q),
    .zero     (zero_fire),
    .ctl_act  (ctl_act),
    .lim_act  (lim_act),
    .ctl_stg  (ctl_stg),
    .lim_stg  (lim_stg),
    .cmd_last (cmd_last)
  );

  arb_evstat_hist u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (zero_fire),
    .g     (g),
    .turn  (turn_ev),
    .again (again_ev)
  );

  for (genvar gi = 0; gi < NGATH; gi++) begin : g_gath
    arb_evstat_gather #(.CNT_W(CNT_W)) u_gath (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .zero  (zero_fire),
      .ctl   (ctl_act[gi]),
      .g     (g),
      .turn  (turn_ev),
      .again (again_ev),
      .inc   (inc[gi]),
      .cnt   (cnt_q[gi])
    );
  end

  // Window length: stops at the working limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            clk_cnt <= '0;
    else if (zero_fire)                    clk_cnt <= '0;
    else if (en_q && (clk_cnt < lim_act))  clk_cnt <= clk_cnt + 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD:    reg_rdata = {22'd0, cmd_last, 8'd0};
      A_LIMIT:  reg_rdata = WORD_W'(lim_stg);
      A_CLOCKS: reg_rdata = WORD_W'(clk_cnt);
      default: begin
        for (int i = 0; i < NGATH; i++) begin
          if (reg_addr == A_CTL0 + ADDR_W'(i)) reg_rdata = ctl_stg[i];
          if (reg_addr == A_CNT0 + ADDR_W'(i)) reg_rdata = WORD_W'(cnt_q[i]);
        end
      end
    endcase
  end

endmodule

// File: rtl/arb_evstat_chk.sv
module arb_evstat_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             zero,
  input logic [CNT_W-1:0] clk_cnt,
  input logic [CNT_W-1:0] lim,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);

  // R3
  clk_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zero && (clk_cnt < lim)) |=> (clk_cnt == $past(clk_cnt) + 1'b1));

  // R3
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zero && (clk_cnt >= lim)) |=> $stable(clk_cnt));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !zero) |=> ($stable(cnt0) && $stable(cnt1) && $stable(clk_cnt)));

  // R4
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero |=> ((cnt0 >= $past(cnt0)) && (cnt1 >= $past(cnt1))));

  // R4
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt0) && !zero) |=> (&cnt0));

  // R2
  zeroing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> ((clk_cnt == '0) && (cnt0 == '0) && (cnt1 == '0)));

endmodule

bind arb_evstat arb_evstat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en_q),
  .zero    (zero_fire),
  .clk_cnt (clk_cnt),
  .lim     (lim_act),
  .cnt0    (cnt_q[0]),
  .cnt1    (cnt_q[1])
);

// File: tb/arb_evstat_test.sv
module arb_evstat_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        g_v, g_w, g_hp, g_tm, g_bw, g_pm, g_aa, g_bb, g_ap;
  logic [5:0]  g_cl;

  arb_evstat uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .gnt_valid(g_v), .gnt_client(g_cl), .gnt_write(g_w),
    .gnt_hp(g_hp), .gnt_tm(g_tm), .gnt_bw(g_bw), .gnt_page_miss(g_pm),
    .gnt_bank_aa(g_aa), .gnt_bank_bb(g_bb), .gnt_auto_pre(g_ap)
  );

  int n_chk = 0;
  int n_fail = 0;
  int unsigned seed_init = $urandom(32'd5813);

  // Reference model, advanced on every rising edge from the driven inputs.
  bit          m_en, m_pv, m_pw;
  logic [5:0]  m_pc;
  logic [31:0] m_stg [2];
  logic [31:0] m_act [2];
  logic [31:0] m_lim_s, m_lim_a, m_clk;
  logic [31:0] m_cnt [2];

  function automatic bit m_hit(input logic [31:0] c);
    bit flag, pass, sel, who;
    flag = (c[25:24] == 2'd0) ? g_hp : (c[25:24] == 2'd1) ? g_tm :
           (c[25:24] == 2'd2) ? g_bw : 1'b0;
    pass = (c[29:28] == 2'd1) ? !flag : (c[29:28] == 2'd2) ? flag : 1'b1;
    who  = (c[26] == 1'b0) || (c[13:8] == g_cl);
    case (c[23:16])
      8'd0: sel = 1'b1;
      8'd1: sel = !g_w;
      8'd2: sel = g_w;
      8'd3: sel = m_pv && (m_pw != g_w);
      8'd4: sel = m_pv && (m_pc == g_cl);
      8'd5: sel = g_aa;
      8'd6: sel = g_bb;
      8'd7: sel = g_pm;
      8'd8: sel = g_ap;
      default: sel = 1'b0;
    endcase
    return g_v && who && pass && sel;
  endfunction

  always @(posedge clk) begin : model
    bit h [2];
    if (!rst_n) begin
      m_en = 0; m_pv = 0; m_pw = 0; m_pc = '0;
      m_lim_s = '1; m_lim_a = '1; m_clk = '0;
      for (int k = 0; k < 2; k++) begin m_stg[k] = '0; m_act[k] = '0; m_cnt[k] = '0; end
    end else begin
      for (int k = 0; k < 2; k++) h[k] = m_hit(m_act[k]);
      if (m_en) begin
        if (m_clk < m_lim_a) m_clk = m_clk + 1;
        for (int k = 0; k < 2; k++)
          if (h[k] && (m_cnt[k] != 32'hffff_ffff)) m_cnt[k] = m_cnt[k] + 1;
      end
      if (g_v) begin m_pv = 1; m_pw = g_w; m_pc = g_cl; end
      if (we) begin
        case (addr)
          3'd0: case (wdata[9:8])
            2'd0: begin
              m_clk = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_pv = 0; m_en = 0;
              m_stg[0] = 0; m_stg[1] = 0; m_lim_s = '1;
            end
            2'd1: begin m_clk = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_pv = 0; end
            2'd2: m_en = 0;
            default: begin
              m_en = 1; m_act[0] = m_stg[0]; m_act[1] = m_stg[1]; m_lim_a = m_lim_s;
            end
          endcase
          3'd1: m_lim_s = wdata;
          3'd2: m_stg[0] = wdata;
          3'd3: m_stg[1] = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_val(input logic [2:0] a);
    case (a)
      3'd1: return m_lim_s;
      3'd2: return m_stg[0];
      3'd3: return m_stg[1];
      3'd4: return m_clk;
      3'd5: return m_cnt[0];
      3'd6: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] mk_ctl(input logic [5:0] cl, input logic [7:0] ev,
                                         input logic [1:0] ps, input logic cf,
                                         input logic [1:0] pm);
    return {2'b00, pm, 1'b0, cf, ps, ev, 2'b00, cl, 8'h00};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, m_val(a));
  endtask

  task automatic rd_lit(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic rd_val(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d; g_v = 0;
    @(posedge clk);
    #1 we = 0;
  endtask

  task automatic cmd(input logic [1:0] c);
    wr(3'd0, {22'd0, c, 8'd0});
  endtask

  task automatic grant(input logic [5:0] cl, input logic w, input logic hp,
                       input logic tm, input logic bw, input logic pm,
                       input logic aa, input logic bb, input logic ap);
    @(negedge clk);
    g_v = 1; g_cl = cl; g_w = w; g_hp = hp; g_tm = tm; g_bw = bw;
    g_pm = pm; g_aa = aa; g_bb = bb; g_ap = ap;
    @(posedge clk);
    #1 g_v = 0;
  endtask

  task automatic rnd_grant();
    logic [8:0] b;
    b = 9'($urandom);
    if (($urandom % 4) == 0) begin
      @(posedge clk);
    end else begin
      grant(6'd3 + 6'($urandom % 3), b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]);
    end
  endtask

  function automatic string ev_req(input int ev);
    if (ev == 3) return "R8";
    if (ev == 4) return "R9";
    if (ev > 8)  return "R13";
    return "R7";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v0, v1;
    rst_n = 0; we = 0; addr = 0; wdata = 0;
    g_v = 0; g_cl = 0; g_w = 0; g_hp = 0; g_tm = 0; g_bw = 0;
    g_pm = 0; g_aa = 0; g_bb = 0; g_ap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd_lit("R1", 3'd1, 32'hffff_ffff);
    rd_lit("R1", 3'd2, 32'd0);
    rd_lit("R1", 3'd4, 32'd0);
    rd_lit("R1", 3'd6, 32'd0);

    // Random runs over every event select, with one gatherer unfiltered by client (R5)
    for (int ev = 0; ev < 10; ev++) begin
      wr(3'd2, mk_ctl(6'd3 + 6'($urandom % 3), 8'(ev), 2'($urandom % 4),
                      1'($urandom % 2), 2'($urandom % 4)));
      wr(3'd3, mk_ctl(6'($urandom % 64), 8'(ev), 2'($urandom % 3), 1'b0,
                      2'($urandom % 3)));
      cmd(2'd1);
      cmd(2'd3);
      for (int n = 0; n < 48; n++) rnd_grant();
      cmd(2'd2);
      rd_chk(ev_req(ev), 3'd5);
      rd_chk("R5", 3'd6);
      rd_chk("R3", 3'd4);
    end
    rd_chk("R4", 3'd5);

    // R6 timeout flag: gatherer 0 counts flag high, gatherer 1 flag low
    wr(3'd2, mk_ctl(6'd0, 8'd0, 2'd1, 1'b0, 2'd2));
    wr(3'd3, mk_ctl(6'd0, 8'd0, 2'd1, 1'b0, 2'd1));
    cmd(2'd1);
    cmd(2'd3);
    grant(6'd1, 0, 1, 1, 0, 0, 0, 0, 0);
    grant(6'd2, 1, 0, 0, 1, 0, 0, 0, 0);
    grant(6'd3, 0, 0, 1, 0, 0, 0, 0, 0);
    grant(6'd4, 1, 1, 0, 0, 0, 0, 0, 0);
    grant(6'd5, 0, 0, 1, 1, 0, 0, 0, 0);
    cmd(2'd2);
    rd_lit("R6", 3'd5, 32'd3);
    rd_lit("R6", 3'd6, 32'd2);

    // R8 and R9: five grants to one client with directions R R W W R
    wr(3'd2, mk_ctl(6'd0, 8'd3, 2'd0, 1'b0, 2'd0));
    wr(3'd3, mk_ctl(6'd9, 8'd4, 2'd0, 1'b1, 2'd0));
    cmd(2'd1);
    cmd(2'd3);
    grant(6'd9, 0, 0, 0, 0, 0, 0, 0, 0);
    grant(6'd9, 0, 0, 0, 0, 0, 0, 0, 0);
    grant(6'd9, 1, 0, 0, 0, 0, 0, 0, 0);
    grant(6'd9, 1, 0, 0, 0, 0, 0, 0, 0);
    grant(6'd9, 0, 0, 0, 0, 0, 0, 0, 0);
    cmd(2'd2);
    rd_lit("R8", 3'd5, 32'd2);
    rd_lit("R9", 3'd6, 32'd4);

    // R10 stopped: grants and cycles change nothing
    rd_val(3'd6, v0);
    rd_val(3'd4, v1);
    for (int n = 0; n < 6; n++) grant(6'd9, 0, 0, 0, 0, 0, 0, 0, 0);
    rd_lit("R10", 3'd6, v0);
    rd_lit("R10", 3'd4, v1);

    // R11 deferred control update
    wr(3'd2, mk_ctl(6'd0, 8'd0, 2'd0, 1'b0, 2'd0));
    cmd(2'd1);
    cmd(2'd3);
    for (int n = 0; n < 4; n++) grant(6'd7, 0, 0, 0, 0, 0, 0, 0, 0);
    wr(3'd2, mk_ctl(6'd0, 8'd9, 2'd0, 1'b0, 2'd0));
    for (int n = 0; n < 3; n++) grant(6'd7, 1, 0, 0, 0, 0, 0, 0, 0);
    cmd(2'd2);
    rd_lit("R11", 3'd5, 32'd7);
    cmd(2'd3);
    for (int n = 0; n < 3; n++) grant(6'd7, 1, 0, 0, 0, 0, 0, 0, 0);
    cmd(2'd2);
    rd_lit("R11", 3'd5, 32'd7);

    // R3 clock limit
    wr(3'd1, 32'd5);
    cmd(2'd1);
    cmd(2'd3);
    repeat (12) @(posedge clk);
    rd_lit("R3", 3'd4, 32'd5);

    // R2 clear while running keeps collection on
    wr(3'd1, 32'd1000);
    cmd(2'd3);
    repeat (4) @(posedge clk);
    cmd(2'd1);
    repeat (3) @(posedge clk);
    rd_chk("R2", 3'd4);
    rd_lit("R2", 3'd5, 32'd0);
    cmd(2'd2);

    // R12 reset command restores staged registers
    wr(3'd3, 32'h1234_5678);
    cmd(2'd0);
    rd_lit("R12", 3'd1, 32'hffff_ffff);
    rd_lit("R12", 3'd2, 32'd0);
    rd_lit("R12", 3'd3, 32'd0);
    rd_lit("R12", 3'd4, 32'd0);

    summary();
    $finish;
  end

endmodule